// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a 16-bit control and status register that remembers why the system came out of its last reset and holds a handful of power and watchdog control bits. Hardware event sources (power-on, brown-out, external reset pin, software reset instruction, watchdog timeout, trap conflict, illegal opcode, configuration mismatch, sleep, idle and deep-sleep wakeup) each deliver a one-cycle pulse. A pulse sets the matching cause flag. The flag stays set until software clears it.

Software reaches the register through a write strobe with 16-bit data and a read port that shows the current contents combinationally. Any flag can be set or cleared by a write. A flag set by software is only a stored value and has no side effect. The block also drives a watchdog-enable output. A configuration-fuse input forces this output on. Otherwise the output follows the software watchdog-enable bit.

`rst_n` is meant to be the power-on reset only. Other resets do not touch this register, so the recorded causes survive them.

Top module: `rst_cause_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register loads 0x0003 (power-on bit 0 and brown-out bit 1 set, every other bit clear), and `rd_data` shows 0x0003 after that edge.
- R2: A pulse on `hw_evt` at a flag position sets that bit at the next edge, and the bit stays set afterwards. The flag positions are 0 power-on, 1 brown-out, 2 idle, 3 sleep, 4 watchdog timeout, 6 software reset, 7 external pin, 9 configuration mismatch, 10 deep sleep, 14 illegal opcode, 15 trap conflict.
- R3: When `wr_en` is high at an edge, every implemented bit, flags and control bits alike, takes the value of `wr_data`. This covers both setting and clearing.
- R4: Bit 11 always reads 0. Writing 1 to it has no effect (a write of 0xFFFF reads back as 0xF7FF).
- R5: If a hardware pulse and a write reach the same flag bit in the same cycle, the bit ends up set. The other bits take the written value.
- R6: `hw_evt` pulses at the control positions (13 software brown-out enable, 12 low-voltage sleep regulator select, 8 program-memory power in sleep, 5 software watchdog enable) and at bit 11 leave the register unchanged.
- R7: While `fuse_wdt_on` is 1, `wdt_en` is 1 whatever bit 5 holds.
- R8: While `fuse_wdt_on` is 0, `wdt_en` equals bit 5 of the register.
- R9: With no write and no event, the register holds its value from cycle to cycle, and `rd_data` always shows the stored value with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Software write data |
| hw_evt | input | 16 | One-cycle hardware event pulses, one per bit position |
| fuse_wdt_on | input | 1 | Configuration fuse that forces the watchdog on |
| rd_data | output | 16 | Current register contents |
| wdt_en | output | 1 | Watchdog enable |

## Verification
Every bit is visible on `rd_data` with no extra latency. A wrong cell value therefore shows on the read port one edge after the stimulus that caused it. A wrong value in bit 5 also shows on `wdt_en` in that same cycle when the fuse is 0. The bench checks each flag and control position on its own, both after a hardware pulse and after a write. This way a swapped or misclassified position is caught at the first edge on which it differs. The cases where a write and an event collide, and the write of 1 to bit 11, are driven on their own so that the set-wins rule and the reserved bit can each be seen to fail.

// File: rtl/rcause_pkg.sv
// Package: bit positions, masks and reset value for the reset-cause register.
// Assumes a 16-bit register; positions are fixed because software decodes them.
package rcause_pkg;
    localparam int REG_W = 16;

    localparam int BIT_POR    = 0;
    localparam int BIT_BOR    = 1;
    localparam int BIT_IDLE   = 2;
    localparam int BIT_SLEEP  = 3;
    localparam int BIT_WDTO   = 4;
    localparam int BIT_WDTSW  = 5;
    localparam int BIT_SWRST  = 6;
    localparam int BIT_EXTPIN = 7;
    localparam int BIT_PMPWR  = 8;
    localparam int BIT_CFGMM  = 9;
    localparam int BIT_DSLP   = 10;
    localparam int BIT_RSV    = 11;
    localparam int BIT_LVSEL  = 12;
    localparam int BIT_BORSW  = 13;
    localparam int BIT_ILLOP  = 14;
    localparam int BIT_TRAP   = 15;

    // Positions that hardware events may set.
    localparam logic [REG_W-1:0] FLAG_MASK =
        (REG_W'(1) << BIT_POR)   | (REG_W'(1) << BIT_BOR)    |
        (REG_W'(1) << BIT_IDLE)  | (REG_W'(1) << BIT_SLEEP)  |
        (REG_W'(1) << BIT_WDTO)  | (REG_W'(1) << BIT_SWRST)  |
        (REG_W'(1) << BIT_EXTPIN)| (REG_W'(1) << BIT_CFGMM)  |
        (REG_W'(1) << BIT_DSLP)  | (REG_W'(1) << BIT_ILLOP)  |
        (REG_W'(1) << BIT_TRAP);

    // Software-only control positions.
    localparam logic [REG_W-1:0] CTRL_MASK =
        (REG_W'(1) << BIT_WDTSW) | (REG_W'(1) << BIT_PMPWR)  |
        (REG_W'(1) << BIT_LVSEL) | (REG_W'(1) << BIT_BORSW);

    localparam logic [REG_W-1:0] IMPL_MASK = FLAG_MASK | CTRL_MASK;

    localparam logic [REG_W-1:0] POR_VALUE =
        (REG_W'(1) << BIT_POR) | (REG_W'(1) << BIT_BOR);
endpackage

// File: rtl/rcause_cell.sv
// One storage bit of the reset-cause register.
// Assumes hw_pulse is a single-cycle synchronous pulse; when HW_SET is 0
// the pulse is ignored and the bit is software-only.
module rcause_cell #(
    parameter bit HW_SET = 1'b1,
    parameter bit INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_pulse,
    input  logic wr_en,
    input  logic wr_bit,
    output logic q
);
    logic set_now;

    // Purpose: qualify the hardware pulse by whether this bit accepts one.
    assign set_now = HW_SET ? hw_pulse : 1'b0;

    // Purpose: reset to INIT, hardware set beats software write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= INIT;
        else if (set_now)
            q <= 1'b1;
        else if (wr_en)
            q <= wr_bit;
    end
endmodule

// File: rtl/rcause_wdt_gate.sv
// Watchdog-enable combiner: the fuse forces the enable, otherwise the
// software bit decides. Assumes both inputs are static or synchronous.
module rcause_wdt_gate (
    input  logic fuse_force,
    input  logic sw_enable,
    output logic wdt_en
);
    // Purpose: fuse override or software choice.
    always_comb begin
        if (fuse_force)
            wdt_en = 1'b1;
        else
            wdt_en = sw_enable;
    end
endmodule

// File: rtl/rst_cause_reg.sv
// Reset-cause status and control register. Sticky cause flags are set by
// hardware pulses and written by software; control bits are software-only;
// the reserved position is tied to zero. Assumes rst_n is the power-on reset.
module rst_cause_reg
    import rcause_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] hw_evt,
    input  logic             fuse_wdt_on,
    output logic [REG_W-1:0] rd_data,
    output logic             wdt_en
);
    logic [REG_W-1:0] bits_q;
    logic             unused_rsv;

    // Purpose: one cell per implemented position, constant zero elsewhere.
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            rcause_cell #(
                .HW_SET (FLAG_MASK[i]),
                .INIT   (POR_VALUE[i])
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .hw_pulse (hw_evt[i]),
                .wr_en    (wr_en),
                .wr_bit   (wr_data[i]),
                .q        (bits_q[i])
            );
        end else begin : g_rsv
            assign bits_q[i] = 1'b0;
        end
    end

    // Purpose: reserved-position inputs are deliberately dropped.
    assign unused_rsv = hw_evt[BIT_RSV] ^ wr_data[BIT_RSV];

    // Purpose: read port shows stored value without delay.
    assign rd_data = bits_q;

    rcause_wdt_gate u_wdt (
        .fuse_force (fuse_wdt_on),
        .sw_enable  (bits_q[BIT_WDTSW]),
        .wdt_en     (wdt_en)
    );
endmodule

// File: rtl/rcause_chk.sv
// Assertion checker for rst_cause_reg, attached by bind below.
module rcause_chk
    import rcause_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] hw_evt,
    input logic             fuse_wdt_on,
    input logic [REG_W-1:0] rd_data,
    input logic             wdt_en
);
    // R2: flagged events are visible as set bits one edge later.
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_evt & FLAG_MASK) != '0) |=>
        ((rd_data & $past(hw_evt & FLAG_MASK)) == $past(hw_evt & FLAG_MASK)));

    // R3, R4: a write with no event loads the implemented bits only.
    p_write_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hw_evt == '0) |=> (rd_data == $past(wr_data & IMPL_MASK)));

    // R5: written-zero flag with a same-cycle event ends set.
    p_evt_beats_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((hw_evt & FLAG_MASK & ~wr_data) != '0)) |=>
        ((rd_data & $past(hw_evt & FLAG_MASK)) == $past(hw_evt & FLAG_MASK)));

    // R6: without a write, control bits never move.
    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_data & CTRL_MASK) == $past(rd_data & CTRL_MASK)));

    // R7: fuse forces the enable.
    p_fuse_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_wdt_on |-> wdt_en);

    // R8: no fuse, enable tracks bit 5.
    p_sw_wdt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fuse_wdt_on |-> (wdt_en == rd_data[BIT_WDTSW]));

    // R9: quiet cycles leave the register stable.
    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hw_evt == '0) |=> $stable(rd_data));
endmodule

bind rst_cause_reg rcause_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .hw_evt      (hw_evt),
    .fuse_wdt_on (fuse_wdt_on),
    .rd_data     (rd_data),
    .wdt_en      (wdt_en)
);

// File: tb/sim_rst_cause_reg.sv
// Scoreboard bench: driver pushes expected results, monitor pops and compares.
module sim_rst_cause_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] hw_evt = '0;
    logic        fuse_wdt_on = 1'b0;
    logic [15:0] rd_data;
    logic        wdt_en;

    localparam logic [15:0] FLAGS = 16'hC6DF;
    localparam logic [15:0] CTRLS = 16'h3120;
    localparam logic [15:0] IMPL  = 16'hF7FF;

    typedef struct {
        logic [15:0] rd;
        logic        wdt;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] model = 16'h0003;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    rst_cause_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hw_evt(hw_evt), .fuse_wdt_on(fuse_wdt_on),
        .rd_data(rd_data), .wdt_en(wdt_en)
    );

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic drive(input logic rst, input logic wr, input logic [15:0] wd,
                         input logic [15:0] evt, input logic fuse, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = ~rst; wr_en = wr; wr_data = wd; hw_evt = evt; fuse_wdt_on = fuse;
        if (rst) model = 16'h0003;
        else begin
            if (wr) model = wd & IMPL;
            model = model | (evt & FLAGS);
        end
        e.rd = model;
        e.wdt = fuse | model[5];
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after each edge, once outputs have settled.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (rd_data !== e.rd || wdt_en !== e.wdt) begin
                n_fail++;
                $display("FAIL %s rd_data=%h wdt_en=%b expected rd_data=%h wdt_en=%b",
                         e.tag, rd_data, wdt_en, e.rd, e.wdt);
            end
        end
    end

    initial begin
        drive(1, 0, 16'h0, 16'h0, 0, "R1");
        drive(1, 0, 16'h0, 16'h0, 0, "R1");
        drive(0, 0, 16'h0, 16'h0, 0, "R9");
        drive(0, 0, 16'h0, 16'h0, 0, "R9");
        drive(0, 1, 16'h0, 16'h0, 0, "R3");
        for (int b = 0; b < 16; b++) begin
            if (FLAGS[b]) drive(0, 0, 16'h0, 16'h1 << b, 0, "R2");
            else          drive(0, 0, 16'h0, 16'h1 << b, 0, "R6");
            drive(0, 0, 16'h0, 16'h0, 0, "R9");
        end
        drive(0, 1, 16'h0, 16'h0, 0, "R3");
        drive(0, 0, 16'h0, 16'h0, 0, "R9");
        drive(0, 1, 16'hFFFF, 16'h0, 0, "R4");
        drive(0, 1, 16'h0800, 16'h0, 0, "R4");
        drive(0, 1, CTRLS, 16'h0, 0, "R3");
        drive(0, 1, 16'h1234, 16'h0, 0, "R3");
        drive(0, 1, 16'h0020, 16'h0, 0, "R8");
        drive(0, 1, 16'h0000, 16'h0, 0, "R8");
        drive(0, 0, 16'h0000, 16'h0, 1, "R7");
        drive(0, 1, 16'h0020, 16'h0, 1, "R7");
        drive(0, 0, 16'h0000, 16'h0, 0, "R8");
        drive(0, 1, 16'h0000, 16'h8010, 0, "R5");
        drive(0, 1, 16'h0001, 16'h0400, 0, "R5");
        drive(0, 1, 16'hFFFF, 16'hFFFF, 0, "R5");
        drive(0, 0, 16'h0000, CTRLS | 16'h0800, 0, "R6");
        drive(1, 0, 16'h0000, 16'h0, 0, "R1");
        drive(0, 0, 16'h0000, 16'h0, 0, "R9");
        @(negedge clk);
        wr_en = 0; hw_evt = '0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired rd_data=%h expected completion", rd_data);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule